// File: doc/BRIEF.md
# Register File with Hardwired Zero Entry

This block is the general-purpose register bank of a small processor. It holds a configurable number of data words, between 2 and 16, and serves two independent read ports and one write port. Both read ports are combinational: a read port's data follows its address input within the same cycle, with no clock edge in between. The write port commits one word on the rising clock edge while its enable is high.

Entry 0 is a constant zero. No storage is built for it. A write addressed to it is dropped, and a read of it returns zero. This gives the instruction encoding a free zero source and a discard destination. A synchronous active-high reset clears every stored entry. A read of the entry being written in the same cycle sees the value from before the edge, because the block has no internal bypass. Forwarding is left to the surrounding pipeline. When the register count is not a power of two, some address codes name no entry. Writes to those codes are dropped and reads of them return zero.

Top module: `regbank_zr`

## Requirements
- R1: While `rst` is high at a rising edge, every stored entry is cleared, so after that edge every read port returns zero for every address.
- R2: When `wr_en` is high at a rising edge and `wr_addr` names an entry from 1 to REG_COUNT-1, that entry takes `wr_data`. A read of that address returns the new value from just after the edge.
- R3: When `wr_en` is low at an edge, no entry changes, whatever `wr_addr` and `wr_data` hold.
- R4: A read at address 0 on either port always returns zero.
- R5: A write with `wr_addr` equal to 0 has no effect: address 0 still reads zero, and every other entry keeps its value.
- R6: Each read port's data follows a change of its address within the same cycle, without waiting for a clock edge.
- R7: A read of the entry being written returns the old value until the write edge, and the new value after it. There is no bypass from `wr_data`.
- R8: When both read ports carry the same address, they return the same value.
- R9: Address codes from REG_COUNT to 2^ADDR_W-1 name no entry. A write to one of them changes nothing, and a read of one of them returns zero.
- R10: When `rst` and `wr_en` are both high at the same edge, the reset wins and the addressed entry reads zero afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset, clears all entries |
| wr_en | input | 1 | Write enable for the single write port |
| wr_addr | input | ADDR_W | Entry written when `wr_en` is high |
| wr_data | input | DATA_W | Word written |
| rd_a_addr | input | ADDR_W | Address of read port A |
| rd_a_data | output | DATA_W | Combinational data of read port A |
| rd_b_addr | input | ADDR_W | Address of read port B |
| rd_b_data | output | DATA_W | Combinational data of read port B |

ADDR_W is ceil(log2(REG_COUNT)), with a minimum of 1.

## Verification
The bench builds two copies of the block.

The main copy has six 16-bit entries. Because six is not a power of two, its 3-bit address leaves codes 6 and 7 unmapped. This copy therefore covers the dropped writes and zero reads of R9, as well as hold, reset priority, same-cycle old-value reads and the hardwired zero entry.

The second copy uses the smallest legal size: two 8-bit entries with a 1-bit address. In that copy only entry 1 is writable, which exercises the degenerate decode and read-select paths at their narrowest width.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

  // Address width for a bank of n entries, never below one bit.
  function automatic int addr_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/rb_wr_decode.sv
module rb_wr_decode #(
  parameter int REG_COUNT = 8,
  parameter int ADDR_W    = 3
) (
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  output logic [REG_COUNT-1:0] wr_sel
);

  // Entry 0 never gets a select; unmapped codes match no entry.
  assign wr_sel[0] = 1'b0;

  for (genvar i = 1; i < REG_COUNT; i++) begin : g_sel
    assign wr_sel[i] = wr_en && (wr_addr == ADDR_W'(i));
  end

endmodule

// File: rtl/rb_cells.sv
module rb_cells #(
  parameter int REG_COUNT = 8,
  parameter int DATA_W    = 8
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [REG_COUNT-1:0]             wr_sel,
  input  logic [DATA_W-1:0]                wr_data,
  output logic [REG_COUNT-1:0][DATA_W-1:0] cell_q
);

  // Entry 0 is a constant; no flops are built for it.
  assign cell_q[0] = '0;

  for (genvar i = 1; i < REG_COUNT; i++) begin : g_cell
    always_ff @(posedge clk) begin
      if (rst) begin
        cell_q[i] <= '0;
      end else if (wr_sel[i]) begin
        cell_q[i] <= wr_data;
      end
    end
  end

endmodule

// File: rtl/rb_rd_mux.sv
module rb_rd_mux #(
  parameter int REG_COUNT = 8,
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 3
) (
  input  logic [REG_COUNT-1:0][DATA_W-1:0] cell_q,
  input  logic [ADDR_W-1:0]                rd_addr,
  output logic [DATA_W-1:0]                rd_data
);

  // Default zero covers entry 0 and any unmapped address code.
  always_comb begin
    rd_data = '0;
    for (int i = 1; i < REG_COUNT; i++) begin
      if (rd_addr == ADDR_W'(i)) begin
        rd_data = cell_q[i];
      end
    end
  end

endmodule

// File: rtl/regbank_zr.sv
module regbank_zr #(
  parameter int REG_COUNT = 8,
  parameter int DATA_W    = 8,
  localparam int ADDR_W   = regbank_pkg::addr_bits(REG_COUNT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_a_addr,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [ADDR_W-1:0] rd_b_addr,
  output logic [DATA_W-1:0] rd_b_data
);

  logic [REG_COUNT-1:0]             wr_sel;
  logic [REG_COUNT-1:0][DATA_W-1:0] cell_q;

  rb_wr_decode #(.REG_COUNT(REG_COUNT), .ADDR_W(ADDR_W)) u_dec (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_sel  (wr_sel)
  );

  rb_cells #(.REG_COUNT(REG_COUNT), .DATA_W(DATA_W)) u_cells (
    .clk     (clk),
    .rst     (rst),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .cell_q  (cell_q)
  );

  rb_rd_mux #(.REG_COUNT(REG_COUNT), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd_a (
    .cell_q  (cell_q),
    .rd_addr (rd_a_addr),
    .rd_data (rd_a_data)
  );

  rb_rd_mux #(.REG_COUNT(REG_COUNT), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd_b (
    .cell_q  (cell_q),
    .rd_addr (rd_b_addr),
    .rd_data (rd_b_data)
  );

endmodule

// File: rtl/regbank_zr_chk.sv
module regbank_zr_chk #(
  parameter int REG_COUNT = 8,
  parameter int DATA_W    = 8,
  localparam int ADDR_W   = regbank_pkg::addr_bits(REG_COUNT)
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [ADDR_W-1:0] rd_a_addr,
  input logic [DATA_W-1:0] rd_a_data,
  input logic [ADDR_W-1:0] rd_b_addr,
  input logic [DATA_W-1:0] rd_b_data
);

  // R1
  reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rd_a_data == '0 && rd_b_data == '0));

  // R2
  write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr != '0 && int'(wr_addr) < REG_COUNT) |=>
      ((rd_a_addr != $past(wr_addr)) || (rd_a_data == $past(wr_data))));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> (!$stable(rd_a_addr) || $stable(rd_a_data)));

  // R4
  zero_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_a_addr == '0) |-> (rd_a_data == '0));

  // R5
  zero_write_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == '0) |=> (!$stable(rd_b_addr) || $stable(rd_b_data)));

  // R8
  ports_agree_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_a_addr == rd_b_addr) |-> (rd_a_data == rd_b_data));

  // R9
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(rd_b_addr) >= REG_COUNT) |-> (rd_b_data == '0));

endmodule

bind regbank_zr regbank_zr_chk #(.REG_COUNT(REG_COUNT), .DATA_W(DATA_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .rd_a_addr (rd_a_addr),
  .rd_a_data (rd_a_data),
  .rd_b_addr (rd_b_addr),
  .rd_b_data (rd_b_data)
);

// File: tb/regbank_zr_tb_top.sv
module regbank_zr_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;

  // Main instance: 6 entries x 16 bits, 3-bit addresses (codes 6,7 unmapped)
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  ra = '0, rb = '0;
  logic [15:0] da, db;

  // Minimal instance: 2 entries x 8 bits, 1-bit addresses
  logic        m_wr_en = 1'b0;
  logic [0:0]  m_wr_addr = '0;
  logic [7:0]  m_wr_data = '0;
  logic [0:0]  m_ra = '0, m_rb = '0;
  logic [7:0]  m_da, m_db;

  int compared   = 0;
  int mismatched = 0;
  logic [15:0] model [8];

  always #10 clk = ~clk;

  regbank_zr #(.REG_COUNT(6), .DATA_W(16)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_a_addr(ra), .rd_a_data(da), .rd_b_addr(rb), .rd_b_data(db)
  );

  regbank_zr #(.REG_COUNT(2), .DATA_W(8)) dut_min_i (
    .clk(clk), .rst(rst), .wr_en(m_wr_en), .wr_addr(m_wr_addr), .wr_data(m_wr_data),
    .rd_a_addr(m_ra), .rd_a_data(m_da), .rd_b_addr(m_rb), .rd_b_data(m_db)
  );

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Drive both ports to addr, settle, compare both with exp.
  task automatic rd_both(input string req, input logic [2:0] addr, input logic [15:0] exp);
    ra = addr; rb = addr;
    #1;
    chk(req, $sformatf("portA addr %0d", addr), da, exp);
    chk(req, $sformatf("portB addr %0d", addr), db, exp);
  endtask

  task automatic write1(input logic [2:0] addr, input logic [15:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = addr; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < 8; i++) rd_both(req, 3'(i), model[i]);
  endtask

  task automatic t_reset_state;
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 8; i++) model[i] = '0;
    check_all("R1");
  endtask

  task automatic t_write_read;
    for (int i = 1; i < 6; i++) begin
      write1(3'(i), 16'h1100 * 16'(i) + 16'h0035);
      model[i] = 16'h1100 * 16'(i) + 16'h0035;
    end
    check_all("R2");
  endtask

  task automatic t_hold;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = 3'd2; wr_data = 16'hDEAD;
    repeat (3) @(negedge clk);
    check_all("R3");
  endtask

  task automatic t_zero_entry;
    rd_both("R4", 3'd0, 16'h0000);
    write1(3'd0, 16'hFFFF);
    rd_both("R5", 3'd0, 16'h0000);
    check_all("R5");
  endtask

  task automatic t_comb_read;
    @(negedge clk);
    ra = 3'd1; rb = 3'd5; #1;
    chk("R6", "portA to 1", da, model[1]);
    chk("R6", "portB to 5", db, model[5]);
    ra = 3'd4; rb = 3'd2; #1;
    chk("R6", "portA to 4 same cycle", da, model[4]);
    chk("R6", "portB to 2 same cycle", db, model[2]);
  endtask

  task automatic t_old_value;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd3; wr_data = 16'hBEEF;
    ra = 3'd3; rb = 3'd3; #1;
    chk("R7", "before edge portA", da, model[3]);
    chk("R7", "before edge portB", db, model[3]);
    @(posedge clk); #1;
    wr_en = 1'b0;
    model[3] = 16'hBEEF;
    chk("R7", "after edge portA", da, 16'hBEEF);
  endtask

  task automatic t_same_addr;
    @(negedge clk);
    ra = 3'd4; rb = 3'd4; #1;
    chk("R8", "portA", da, model[4]);
    chk("R8", "ports equal", db, da);
  endtask

  task automatic t_unmapped;
    write1(3'd6, 16'h6666);
    write1(3'd7, 16'h7777);
    rd_both("R9", 3'd6, 16'h0000);
    rd_both("R9", 3'd7, 16'h0000);
    check_all("R9");
  endtask

  task automatic t_reset_priority;
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b1; wr_addr = 3'd2; wr_data = 16'hAAAA;
    @(negedge clk);
    rst = 1'b0; wr_en = 1'b0;
    for (int i = 0; i < 8; i++) model[i] = '0;
    rd_both("R10", 3'd2, 16'h0000);
    check_all("R1");
  endtask

  task automatic t_min_bank;
    @(negedge clk);
    m_wr_en = 1'b1; m_wr_addr = 1'b1; m_wr_data = 8'h5C;
    @(negedge clk);
    m_wr_addr = 1'b0; m_wr_data = 8'hA3;
    @(negedge clk);
    m_wr_en = 1'b0;
    m_ra = 1'b1; m_rb = 1'b0; #1;
    chk("R2", "min bank entry 1", {8'h00, m_da}, 16'h005C);
    chk("R5", "min bank entry 0", {8'h00, m_db}, 16'h0000);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset_state();
    t_write_read();
    t_hold();
    t_zero_entry();
    t_comb_read();
    t_old_value();
    t_same_addr();
    t_unmapped();
    t_min_bank();
    t_reset_priority();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog (all requirements) actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule